// File: doc/BRIEF.md
# Advanced Load Alias Table

This block lets a scheduler hoist a load above stores whose addresses were unknown at schedule time. When such an early load issues, it records the destination register tag together with the byte range it read. Every later store is compared against all recorded ranges, and any entry whose bytes a store touches is dropped. When the program later reaches the original position of the load, a check names the register tag. An entry that is still present means the early value is good and nothing needs to happen. A missing entry produces either a reload request or a branch to recovery code, and the check command selects which.

The table holds a parameterised number of entries (eight by default) and is searched fully associatively by tag. A load to a tag that is already in the table reuses that entry. Otherwise the load takes the lowest free slot. When every slot is occupied, a round-robin pointer chooses the victim. A check that finds its entry also frees it. Each check produces a one-cycle registered response in the cycle after it is presented. Memory access and the register file sit outside this block.

Top module: `aat_table`

## Requirements
- R1: An advanced load (ld_valid) records its tag, address and size. A later check of that tag with no overlapping store in between yields chk_done=1 with chk_ok=1, reload_req=0 and recover_br=0.
- R2: A store covers bytes st_addr to st_addr+2^st_size-1 (size code 0..3 means 1, 2, 4 or 8 bytes). It invalidates every entry whose byte range shares at least one byte with it, including an overlap of a single edge byte. A later check of that tag then misses.
- R3: A store whose byte range only abuts an entry's range, without sharing a byte, leaves that entry valid.
- R4: An advanced load to a tag already held in the table overwrites that entry, and only the new address is watched from then on.
- R5: An empty table fills slots in order from slot 0 upward. With every slot valid and a new tag arriving, the victim is chosen round-robin starting from slot 0, so tags loaded into slots 0 and 1 are evicted first.
- R6: A missed check with chk_mode=0 raises reload_req. A missed check with chk_mode=1 raises recover_br.
- R7: A check of a tag that was never loaded, or whose entry was evicted, is treated as a miss.
- R8: A check that hits frees its entry, so a second check of the same tag misses.
- R9: A store and an advanced load in the same cycle with overlapping ranges leave the new entry valid. The store is treated as the older of the two.
- R10: The response comes out in the cycle after chk_valid. chk_done is high for exactly that cycle, together with exactly one of chk_ok, reload_req and recover_br. All four are low out of reset and in cycles with no check.
- R11: A check is judged against the table as it stood before the same cycle's store. A store in the same cycle as the check does not turn a hit into a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_valid | input | 1 | Advanced load present this cycle |
| ld_tag | input | TAG_W | Destination register tag of the advanced load |
| ld_addr | input | ADDR_W | Byte address read by the advanced load |
| ld_size | input | SZ_W | Log2 of the load's byte count |
| st_valid | input | 1 | Store present this cycle |
| st_addr | input | ADDR_W | Byte address written by the store |
| st_size | input | SZ_W | Log2 of the store's byte count |
| chk_valid | input | 1 | Check present this cycle |
| chk_tag | input | TAG_W | Register tag being checked |
| chk_mode | input | 1 | 0: reload on miss, 1: branch to recovery on miss |
| chk_done | output | 1 | Check response valid |
| chk_ok | output | 1 | Entry intact, early value may be used |
| reload_req | output | 1 | Entry lost, load must be re-issued |
| recover_br | output | 1 | Entry lost, branch to recovery code |

## Verification
The assertions assume that the upstream logic issues at most one load, one store and one check per cycle. They also assume that tags and sizes are driven to legal values whenever their valid bit is high, and that the addresses do not wrap past the top of the address space. The stimulus stays inside these limits. It uses small addresses well below the wrap point and size codes 0 to 3. It holds each valid bit for exactly one cycle per operation. Same-cycle combinations appear only where a requirement defines their order: a store with a load, and a store with a check.

// File: rtl/aat_pkg.sv
package aat_pkg;

  // Action taken when a check finds its entry gone.
  typedef enum logic {
    MISS_RELOAD = 1'b0,
    MISS_BRANCH = 1'b1
  } miss_act_e;

endpackage

// File: rtl/aat_overlap.sv
module aat_overlap #(
  parameter int ADDR_W = 32,
  parameter int SZ_W   = 2
) (
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [SZ_W-1:0]   a_size_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [SZ_W-1:0]   b_size_i,
  output logic              overlap_o
);
  // One extra bit so the last byte never wraps around.
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] a_lo, a_last, b_lo, b_last;

  always_comb begin
    a_lo      = {1'b0, a_addr_i};
    b_lo      = {1'b0, b_addr_i};
    a_last    = a_lo + ((EW'(1) << a_size_i) - EW'(1));
    b_last    = b_lo + ((EW'(1) << b_size_i) - EW'(1));
    overlap_o = (a_lo <= b_last) && (b_lo <= a_last);
  end

endmodule

// File: rtl/aat_victim.sv
module aat_victim #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]              tag_i,
  input  logic [IDX_W-1:0]              rr_i,
  output logic [IDX_W-1:0]              slot_o,
  output logic                          use_rr_o
);
  logic             tag_hit, free_any;
  logic [IDX_W-1:0] tag_idx, free_idx;

  // Scan downward so the lowest matching or free slot wins.
  always_comb begin
    tag_hit  = 1'b0;
    tag_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid_i[i] && (tags_i[i] == tag_i)) begin
        tag_hit = 1'b1;
        tag_idx = IDX_W'(i);
      end
      if (!valid_i[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    use_rr_o = !tag_hit && !free_any;
    slot_o   = tag_hit ? tag_idx : (free_any ? free_idx : rr_i);
  end

endmodule

// File: rtl/aat_table.sv
module aat_table
  import aat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int ADDR_W  = 32,
  parameter int SZ_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SZ_W-1:0]   ld_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SZ_W-1:0]   st_size,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic              chk_mode,
  output logic              chk_done,
  output logic              chk_ok,
  output logic              reload_req,
  output logic              recover_br
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Table state.
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;
  logic [ENTRIES-1:0][SZ_W-1:0]   sz_q;
  logic [IDX_W-1:0]               rr_q, rr_d;

  logic [ENTRIES-1:0] st_ovl, st_kill, chk_match, wr_en;
  logic [IDX_W-1:0]   ld_slot;
  logic               ld_use_rr, chk_hit;
  logic               done_d, ok_d, reload_d, recover_d;
  miss_act_e          miss_act;

  assign miss_act = miss_act_e'(chk_mode);

  aat_victim #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_victim (
    .valid_i (valid_q),
    .tags_i  (tag_q),
    .tag_i   (ld_tag),
    .rr_i    (rr_q),
    .slot_o  (ld_slot),
    .use_rr_o(ld_use_rr)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    aat_overlap #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_ovl (
      .a_addr_i (addr_q[e]),
      .a_size_i (sz_q[e]),
      .b_addr_i (st_addr),
      .b_size_i (st_size),
      .overlap_o(st_ovl[e])
    );
    assign st_kill[e]   = st_valid & valid_q[e] & st_ovl[e];
    assign chk_match[e] = valid_q[e] & (tag_q[e] == chk_tag);
    assign wr_en[e]     = ld_valid & (ld_slot == IDX_W'(e));

    AST_STORE_KILLS: assert property (@(posedge clk) disable iff (!rst_ni)
      (st_kill[e] && !wr_en[e]) |=> !valid_q[e]);                 // R2
    AST_HIT_FREES: assert property (@(posedge clk) disable iff (!rst_ni)
      (chk_valid && chk_match[e] && !wr_en[e]) |=> !valid_q[e]);  // R8
    AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_ni)
      wr_en[e] |=> valid_q[e]);                                   // R9

    for (genvar f = e + 1; f < ENTRIES; f++) begin : g_pair
      AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_ni)
        !(valid_q[e] && valid_q[f] && (tag_q[e] == tag_q[f])));   // R4
    end
  end

  assign chk_hit = |chk_match;

  // Next state: store and check clear first, the new load sets last.
  always_comb begin
    valid_d = valid_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (st_kill[i] || (chk_valid && chk_match[i])) valid_d[i] = 1'b0;
      if (wr_en[i])                                  valid_d[i] = 1'b1;
    end
    rr_d = rr_q;
    if (ld_valid && ld_use_rr)
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    done_d    = chk_valid;
    ok_d      = chk_valid &&  chk_hit;
    reload_d  = chk_valid && !chk_hit && (miss_act == MISS_RELOAD);
    recover_d = chk_valid && !chk_hit && (miss_act == MISS_BRANCH);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      rr_q       <= '0;
      chk_done   <= 1'b0;
      chk_ok     <= 1'b0;
      reload_req <= 1'b0;
      recover_br <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      rr_q       <= rr_d;
      chk_done   <= done_d;
      chk_ok     <= ok_d;
      reload_req <= reload_d;
      recover_br <= recover_d;
    end
  end

  // Entry payload: no reset, written only when its slot is chosen.
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en[i]) begin
        tag_q[i]  <= ld_tag;
        addr_q[i] <= ld_addr;
        sz_q[i]   <= ld_size;
      end
    end
  end

  AST_RESP_ONE: assert property (@(posedge clk) disable iff (!rst_ni)
    chk_done |-> ($countones({chk_ok, reload_req, recover_br}) == 1));  // R10
  AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !chk_done |-> !(chk_ok || reload_req || recover_br));               // R10
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_ni)
    chk_valid |=> chk_done);                                            // R10
  AST_RR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_ni)
    (rr_q != $past(rr_q)) |-> $past(&valid_q));                         // R5

endmodule

// File: tb/aat_table_bench.sv
`timescale 1ns/1ps
module aat_table_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid, st_valid, chk_valid, chk_mode;
  logic [5:0]  ld_tag, chk_tag;
  logic [31:0] ld_addr, st_addr;
  logic [1:0]  ld_size, st_size;
  logic        chk_done, chk_ok, reload_req, recover_br;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  aat_table u_aat_table (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_mode(chk_mode),
    .chk_done(chk_done), .chk_ok(chk_ok), .reload_req(reload_req), .recover_br(recover_br)
  );

  // Expected response codes: 0 none, 1 ok, 2 reload, 3 recover.
  typedef struct packed {
    logic        ld_v;
    logic [5:0]  ld_t;
    logic [31:0] ld_a;
    logic [1:0]  ld_s;
    logic        st_v;
    logic [31:0] st_a;
    logic [1:0]  st_s;
    logic        ck_v;
    logic [5:0]  ck_t;
    logic        ck_m;
    logic [1:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd3,  32'h100, 2'd2, 1'b0, 32'h0,   2'd0, 1'b0, 6'd0,  1'b0, 2'd0, 8'd1},  // R1 load
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 6'd3,  1'b0, 2'd1, 8'd1},  // R1 hit
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 6'd3,  1'b0, 2'd2, 8'd8},  // R8 consumed
    '{1'b1, 6'd5,  32'h200, 2'd3, 1'b0, 32'h0,   2'd0, 1'b0, 6'd0,  1'b0, 2'd0, 8'd3},
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b1, 32'h208, 2'd0, 1'b0, 6'd0,  1'b0, 2'd0, 8'd3},  // R3 abutting
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 6'd5,  1'b0, 2'd1, 8'd3},  // R3 still ok
    '{1'b1, 6'd5,  32'h200, 2'd3, 1'b0, 32'h0,   2'd0, 1'b0, 6'd0,  1'b0, 2'd0, 8'd2},
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b1, 32'h1FF, 2'd1, 1'b0, 6'd0,  1'b0, 2'd0, 8'd2},  // R2 first byte
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 6'd5,  1'b1, 2'd3, 8'd6},  // R6 R2 branch
    '{1'b1, 6'd7,  32'h300, 2'd0, 1'b0, 32'h0,   2'd0, 1'b0, 6'd0,  1'b0, 2'd0, 8'd4},
    '{1'b1, 6'd7,  32'h400, 2'd0, 1'b0, 32'h0,   2'd0, 1'b0, 6'd0,  1'b0, 2'd0, 8'd4},  // R4 overwrite
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b1, 32'h300, 2'd0, 1'b0, 6'd0,  1'b0, 2'd0, 8'd4},  // R4 old addr
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 6'd7,  1'b0, 2'd1, 8'd4},
    '{1'b1, 6'd9,  32'h500, 2'd1, 1'b1, 32'h500, 2'd1, 1'b0, 6'd0,  1'b0, 2'd0, 8'd9},  // R9
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 6'd9,  1'b0, 2'd1, 8'd9},
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 6'd20, 1'b1, 2'd3, 8'd7},  // R7
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 6'd21, 1'b0, 2'd2, 8'd7},  // R7 R6
    '{1'b1, 6'd10, 32'h600, 2'd2, 1'b0, 32'h0,   2'd0, 1'b0, 6'd0,  1'b0, 2'd0, 8'd2},
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b1, 32'h603, 2'd0, 1'b0, 6'd0,  1'b0, 2'd0, 8'd2},  // R2 last byte
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 6'd10, 1'b0, 2'd2, 8'd2},
    '{1'b1, 6'd12, 32'h700, 2'd0, 1'b0, 32'h0,   2'd0, 1'b0, 6'd0,  1'b0, 2'd0, 8'd11},
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b1, 32'h700, 2'd0, 1'b1, 6'd12, 1'b0, 2'd1, 8'd11}, // R11
    '{1'b0, 6'd0,  32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 6'd12, 1'b1, 2'd3, 8'd8}   // R8
  };

  function automatic logic [3:0] code_bits(logic [1:0] c);
    case (c)
      2'd1:    return 4'b1100;
      2'd2:    return 4'b1010;
      2'd3:    return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic expect_resp(logic [1:0] c, int req, string what);
    logic [3:0] got, want;
    got  = {chk_done, chk_ok, reload_req, recover_br};
    want = code_bits(c);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL R%0d %s: {done,ok,reload,recover} actual %b expected %b", req, what, got, want);
    end
  endtask

  task automatic idle();
    ld_valid = 1'b0; ld_tag = '0; ld_addr = '0; ld_size = '0;
    st_valid = 1'b0; st_addr = '0; st_size = '0;
    chk_valid = 1'b0; chk_tag = '0; chk_mode = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic load(logic [5:0] t, logic [31:0] a);
    idle();
    ld_valid = 1'b1; ld_tag = t; ld_addr = a; ld_size = 2'd0;
    @(negedge clk);
    idle();
  endtask

  task automatic check(logic [5:0] t, logic m, logic [1:0] c, int req, string what);
    idle();
    chk_valid = 1'b1; chk_tag = t; chk_mode = m;
    @(negedge clk);
    idle();
    expect_resp(c, req, what);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    expect_resp(2'd0, 10, "reset state");  // R10

    for (int k = 0; k < NV; k++) begin
      ld_valid  = VECS[k].ld_v; ld_tag = VECS[k].ld_t;
      ld_addr   = VECS[k].ld_a; ld_size = VECS[k].ld_s;
      st_valid  = VECS[k].st_v; st_addr = VECS[k].st_a; st_size = VECS[k].st_s;
      chk_valid = VECS[k].ck_v; chk_tag = VECS[k].ck_t; chk_mode = VECS[k].ck_m;
      @(negedge clk);
      expect_resp(VECS[k].exp, int'(VECS[k].req), $sformatf("vector %0d", k));
    end
    idle();
    @(negedge clk);
    expect_resp(2'd0, 10, "idle after check");  // R10

    // R5: fill every slot, then two more tags evict slots 0 and 1.
    do_reset();
    for (int t = 0; t < 8; t++) load(6'(t), 32'h1000 + 32'(t * 16));
    load(6'd40, 32'h2000);
    load(6'd41, 32'h2010);
    check(6'd0,  1'b0, 2'd2, 5, "slot0 evicted");
    check(6'd1,  1'b1, 2'd3, 5, "slot1 evicted");
    check(6'd2,  1'b0, 2'd1, 5, "slot2 kept");
    check(6'd40, 1'b0, 2'd1, 5, "new tag 40 present");
    check(6'd41, 1'b0, 2'd1, 5, "new tag 41 present");
    check(6'd7,  1'b0, 2'd1, 5, "slot7 kept");

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule